// File: doc/BRIEF.md
# Channel-Operand Streaming RISC Core

This block is a compact 32-bit processor for small glue jobs in a streaming fabric: adding two streams, steering words between channels, splitting or merging flows, and packing or unpacking 16-bit halves. Two input channels and two output channels, each with a valid/accept handshake, act as instruction operands. An instruction can take its first source from an input channel and send its result to an output channel, in the same way that it names a register. The core stalls as a whole whenever a named input has no word or a named output cannot take one. Flow control therefore replaces any schedule.

Code and data share one 64-word by 16-bit local memory. The memory is filled through a dedicated load port while the core is held in reset. The core then runs from address 0 through three stages linked by handshakes: fetch into an instruction register, execute, and one registered slot per output channel. Loops set up by a loop instruction repeat their body with no branch instruction and no lost cycle.

Top module: `chan_risc`

## Requirements
- R1: Instructions are 16 bits: opcode [15:12], dst [11:9], src1 [8:6], src2 [5:3], aux [2:0]. Opcodes 1 to 6 perform, on 32 bits, dst = src1+src2, src1-src2, src1&src2, src1|src2, src1^src2, and src1 (move). Opcode 0 and opcodes 14 to 15 do nothing.
- R2: Opcode 7 adds and opcode 8 subtracts the upper and lower 16-bit halves independently. No carry or borrow crosses bit 15.
- R3: Opcode 11 loads a loop counter from register src1 and sets the loop end to address {src2,aux}. The loop start is the address after the loop instruction. When the fetch address equals the loop end and the counter is nonzero, the next fetch is the loop start and the counter decrements. A counter of N runs the body N+1 times, back to back, with no idle cycle.
- R4: For opcodes 1 to 8, aux[2]=1 takes src1 from input channel src1[0], and aux[1]=1 sends the result to output channel dst[0] instead of a register. An instruction therefore uses at most one input and at most one output channel.
- R5: An input word is consumed only at an edge where both its valid and its accept are high. Input words are consumed in order. Output words leave in order, one per edge at which valid and accept are both high.
- R6: While an output is valid and not accepted, its valid and data hold.
- R7: If the current instruction names an input channel with no valid word, or an output channel whose slot is full and not being accepted, the instruction does not complete. No input is accepted and the fetch stage holds.
- R8: Opcode 10 jumps to address {src2,aux} when register src1 is zero, and falls through otherwise. A taken jump discards the already fetched instruction.
- R9: Opcode 9 writes the 9-bit field {src1,src2,aux}, zero-extended, into register dst. Opcode 13 stores the low 16 bits of register src1 at memory address {src2,aux}. Opcode 12 loads that word, zero-extended, into register dst.
- R10: While rst_n is low, no output is valid and no input is accepted, all registers read as zero, and the load port writes memory. After release, execution starts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| ld_we | input | 1 | Memory load strobe, honoured while in reset |
| ld_addr | input | 6 | Memory load address |
| ld_data | input | 16 | Memory load word |
| in_data | input | 2x32 | Input channel data, index = channel |
| in_valid | input | 2 | Input channel word present |
| in_accept | output | 2 | Input channel word taken this edge |
| out_data | output | 2x32 | Output channel data |
| out_valid | output | 2 | Output channel word present |
| out_accept | input | 2 | Downstream takes the output word |

## Verification
The bench targets lane isolation in the dual 16-bit operations with operands that overflow the low half. A design that let the carry cross bit 15 would return a wrong upper half. It holds an output full under backpressure: a core that failed to stall would overwrite the held word or drain inputs early. It times a one-instruction loop body, where an off-by-one in the counter gives four or six words instead of five, and a late loop check inserts a gap between words. It also runs a branch that must fall through and a self-branch that must spin without touching the inputs.

// File: rtl/chan_risc_pkg.sv
package chan_risc_pkg;
  localparam int NCH = 2;          // channel count fixed by the 1-bit channel select
  localparam int FW  = 3;          // operand field width
  localparam int TW  = 2 * FW;     // jump/memory target width {src2,aux}

  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_AND  = 4'd3;
  localparam logic [3:0] OP_OR   = 4'd4;
  localparam logic [3:0] OP_XOR  = 4'd5;
  localparam logic [3:0] OP_MOV  = 4'd6;
  localparam logic [3:0] OP_ADDH = 4'd7;
  localparam logic [3:0] OP_SUBH = 4'd8;
  localparam logic [3:0] OP_LDI  = 4'd9;
  localparam logic [3:0] OP_BZ   = 4'd10;
  localparam logic [3:0] OP_LOOP = 4'd11;
  localparam logic [3:0] OP_LD   = 4'd12;
  localparam logic [3:0] OP_ST   = 4'd13;

  typedef struct packed {
    logic [3:0]    op;
    logic [FW-1:0] dst;
    logic [FW-1:0] s1;
    logic [FW-1:0] s2;
    logic [FW-1:0] aux;
  } instr_t;
endpackage

// File: rtl/chan_risc_ram.sv
module chan_risc_ram #(
  parameter int AW = 6,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr_f,
  output logic [IW-1:0] rdata_f,
  input  logic [AW-1:0] raddr_x,
  output logic [IW-1:0] rdata_x
);
  localparam int DEPTH = 1 << AW;
  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_f = mem[raddr_f];
  assign rdata_x = mem[raddr_x];
endmodule

// File: rtl/chan_risc_fetch.sv
module chan_risc_fetch #(
  parameter int AW = 6,
  parameter int IW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          stall,
  input  logic          redirect,
  input  logic [AW-1:0] redirect_pc,
  input  logic          loop_set,
  input  logic [AW-1:0] loop_end_new,
  input  logic [CW-1:0] loop_cnt_new,
  input  logic [IW-1:0] mem_rdata,
  output logic [AW-1:0] pc,
  output logic [IW-1:0] ir,
  output logic          ir_valid
);
  logic [AW-1:0] pc_q, pc_d, ls_q, ls_d, le_q, le_d;
  logic [CW-1:0] lc_q, lc_d;
  logic [IW-1:0] ir_q, ir_d;
  logic          irv_q, irv_d;
  logic [AW-1:0] eff_start, eff_end;
  logic [CW-1:0] eff_cnt;
  logic          wrap;

  // a loop instruction executing now is seen by this cycle's fetch
  always_comb begin
    eff_start = loop_set ? pc_q : ls_q;
    eff_end   = loop_set ? loop_end_new : le_q;
    eff_cnt   = loop_set ? loop_cnt_new : lc_q;
    wrap      = (eff_cnt != '0) && (pc_q == eff_end);
  end

  always_comb begin
    pc_d  = pc_q;
    ir_d  = ir_q;
    irv_d = irv_q;
    ls_d  = ls_q;
    le_d  = le_q;
    lc_d  = lc_q;
    if (loop_set) begin
      ls_d = pc_q;
      le_d = loop_end_new;
      lc_d = loop_cnt_new;
    end
    if (redirect) begin
      pc_d  = redirect_pc;
      irv_d = 1'b0;
    end else if (!stall) begin
      ir_d  = mem_rdata;
      irv_d = 1'b1;
      if (wrap) begin
        pc_d = eff_start;
        lc_d = eff_cnt - CW'(1);
      end else begin
        pc_d = pc_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ir_q  <= '0;
      irv_q <= 1'b0;
      ls_q  <= '0;
      le_q  <= '0;
      lc_q  <= '0;
    end else begin
      pc_q  <= pc_d;
      ir_q  <= ir_d;
      irv_q <= irv_d;
      ls_q  <= ls_d;
      le_q  <= le_d;
      lc_q  <= lc_d;
    end
  end

  assign pc       = pc_q;
  assign ir       = ir_q;
  assign ir_valid = irv_q;

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    stall |=> $stable(pc_q) && $stable(ir_q));

  assert_loop_wrap_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!stall && !redirect && !loop_set && lc_q != '0 && pc_q == le_q)
      |=> (pc_q == $past(ls_q)) && (lc_q == $past(lc_q) - CW'(1)));

  assert_jump_flush_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    redirect |=> (pc_q == $past(redirect_pc)) && !irv_q);
endmodule

// File: rtl/chan_risc_exec.sv
module chan_risc_exec
  import chan_risc_pkg::*;
#(
  parameter int AW   = TW,
  parameter int IW   = 16,
  parameter int DW   = 32,
  parameter int NREG = 8,
  parameter int CW   = 16
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic [IW-1:0]            ir,
  input  logic                     ir_valid,
  input  logic [NCH-1:0][DW-1:0]   in_data,
  input  logic [NCH-1:0]           in_valid,
  input  logic [NCH-1:0]           out_ready,
  input  logic [IW-1:0]            ram_rdata,
  output logic [NCH-1:0]           in_accept,
  output logic [NCH-1:0]           push,
  output logic [DW-1:0]            push_data,
  output logic                     stall,
  output logic                     redirect,
  output logic [AW-1:0]            target,
  output logic                     loop_set,
  output logic [CW-1:0]            loop_cnt,
  output logic                     ram_we,
  output logic [IW-1:0]            ram_wdata
);
  localparam int HW = DW / 2;
  localparam int RAW = $clog2(NREG);

  instr_t        ins;
  logic [DW-1:0] rf_q [NREG];
  logic [DW-1:0] opa, opb, res;
  logic          rtype, use_in, use_out, in_sel, out_sel, fire, wr_en;

  always_comb begin
    ins     = instr_t'(ir);
    rtype   = (ins.op >= OP_ADD) && (ins.op <= OP_SUBH);
    use_in  = rtype && ins.aux[2];
    use_out = rtype && ins.aux[1];
    in_sel  = ins.s1[0];
    out_sel = ins.dst[0];
    opa     = use_in ? in_data[in_sel] : rf_q[RAW'(ins.s1)];
    opb     = rf_q[RAW'(ins.s2)];
    target  = AW'({ins.s2, ins.aux});
  end

  always_comb begin
    case (ins.op)
      OP_ADD:  res = opa + opb;
      OP_SUB:  res = opa - opb;
      OP_AND:  res = opa & opb;
      OP_OR:   res = opa | opb;
      OP_XOR:  res = opa ^ opb;
      OP_MOV:  res = opa;
      OP_ADDH: res = {opa[DW-1:HW] + opb[DW-1:HW], opa[HW-1:0] + opb[HW-1:0]};
      OP_SUBH: res = {opa[DW-1:HW] - opb[DW-1:HW], opa[HW-1:0] - opb[HW-1:0]};
      OP_LDI:  res = DW'({ins.s1, ins.s2, ins.aux});
      OP_LD:   res = DW'(ram_rdata);
      default: res = '0;
    endcase
  end

  always_comb begin
    stall = ir_valid && ((use_in && !in_valid[in_sel]) ||
                         (use_out && !out_ready[out_sel]));
    fire  = ir_valid && !stall;
    for (int c = 0; c < NCH; c++) begin
      in_accept[c] = fire && use_in && (in_sel == c[0]);
      push[c]      = fire && use_out && (out_sel == c[0]);
    end
    push_data = res;
    wr_en     = fire && ((rtype && !use_out) || ins.op == OP_LDI || ins.op == OP_LD);
    redirect  = fire && (ins.op == OP_BZ) && (opa == '0);
    loop_set  = fire && (ins.op == OP_LOOP);
    loop_cnt  = opa[CW-1:0];
    ram_we    = fire && (ins.op == OP_ST);
    ram_wdata = opa[IW-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) rf_q[r] <= '0;
    end else if (wr_en) begin
      rf_q[RAW'(ins.dst)] <= res;
    end
  end
endmodule

// File: rtl/chan_risc_outreg.sv
module chan_risc_outreg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          accept,
  output logic          ready,
  output logic          valid,
  output logic [DW-1:0] data
);
  logic          full_q, full_d;
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (push) begin
      full_d = 1'b1;
      data_d = push_data;
    end else if (accept) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign ready = !full_q || accept;
  assign valid = full_q;
  assign data  = data_q;

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (full_q && !accept) |=> full_q && $stable(data_q));

  assert_out_drain_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (full_q && accept && !push) |=> !full_q);
endmodule

// File: rtl/chan_risc.sv
module chan_risc
  import chan_risc_pkg::*;
#(
  parameter int AW   = TW,
  parameter int IW   = 16,
  parameter int DW   = 32,
  parameter int NREG = 8,
  parameter int CW   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_we,
  input  logic [AW-1:0]          ld_addr,
  input  logic [IW-1:0]          ld_data,
  input  logic [NCH-1:0][DW-1:0] in_data,
  input  logic [NCH-1:0]         in_valid,
  output logic [NCH-1:0]         in_accept,
  output logic [NCH-1:0][DW-1:0] out_data,
  output logic [NCH-1:0]         out_valid,
  input  logic [NCH-1:0]         out_accept
);
  logic [1:0]     rst_sync_q;
  logic           core_rst_n;
  logic           stall, redirect, loop_set, ex_we, m_we;
  logic [AW-1:0]  pc, target, m_addr;
  logic [IW-1:0]  ir, rd_f, rd_x, ex_wdata, m_wdata;
  logic           ir_valid;
  logic [CW-1:0]  loop_cnt;
  logic [NCH-1:0] push, out_ready;
  logic [DW-1:0]  push_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  always_comb begin
    m_we    = core_rst_n ? ex_we    : ld_we;
    m_addr  = core_rst_n ? target   : ld_addr;
    m_wdata = core_rst_n ? ex_wdata : ld_data;
  end

  chan_risc_ram #(.AW(AW), .IW(IW)) u_ram (
    .clk(clk), .we(m_we), .waddr(m_addr), .wdata(m_wdata),
    .raddr_f(pc), .rdata_f(rd_f), .raddr_x(target), .rdata_x(rd_x)
  );

  chan_risc_fetch #(.AW(AW), .IW(IW), .CW(CW)) u_fetch (
    .clk(clk), .rst_ni(core_rst_n), .stall(stall), .redirect(redirect),
    .redirect_pc(target), .loop_set(loop_set), .loop_end_new(target),
    .loop_cnt_new(loop_cnt), .mem_rdata(rd_f), .pc(pc), .ir(ir),
    .ir_valid(ir_valid)
  );

  chan_risc_exec #(.AW(AW), .IW(IW), .DW(DW), .NREG(NREG), .CW(CW)) u_exec (
    .clk(clk), .rst_ni(core_rst_n), .ir(ir), .ir_valid(ir_valid),
    .in_data(in_data), .in_valid(in_valid), .out_ready(out_ready),
    .ram_rdata(rd_x), .in_accept(in_accept), .push(push),
    .push_data(push_data), .stall(stall), .redirect(redirect),
    .target(target), .loop_set(loop_set), .loop_cnt(loop_cnt),
    .ram_we(ex_we), .ram_wdata(ex_wdata)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_out
    chan_risc_outreg #(.DW(DW)) u_out (
      .clk(clk), .rst_ni(core_rst_n), .push(push[c]), .push_data(push_data),
      .accept(out_accept[c]), .ready(out_ready[c]), .valid(out_valid[c]),
      .data(out_data[c])
    );
  end

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !core_rst_n |-> (out_valid == '0) && (in_accept == '0));
endmodule

// File: tb/chan_risc_test.sv
`timescale 1ns/1ps
module chan_risc_test;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              ld_we;
  logic [5:0]        ld_addr;
  logic [15:0]       ld_data;
  logic [1:0][31:0]  in_data;
  logic [1:0]        in_valid;
  logic [1:0]        in_accept;
  logic [1:0][31:0]  out_data;
  logic [1:0]        out_valid;
  logic [1:0]        out_accept;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  chan_risc uut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .in_data(in_data), .in_valid(in_valid),
    .in_accept(in_accept), .out_data(out_data), .out_valid(out_valid),
    .out_accept(out_accept)
  );

  localparam logic [63:0] VEC [8] = '{
    {32'h00000005, 32'h00000003},
    {32'h0000FFFF, 32'h00000001},
    {32'hFFFFFFFF, 32'h00000001},
    {32'h80000000, 32'h80000000},
    {32'h12345678, 32'h0F0F0F0F},
    {32'h00010000, 32'h00000001},
    {32'hA5A5A5A5, 32'h5A5A5A5A},
    {32'h00000000, 32'hFFFFFFFF}
  };

  function automatic logic [15:0] enc(int op, int d, int s1, int s2, int ax);
    return {op[3:0], d[2:0], s1[2:0], s2[2:0], ax[2:0]};
  endfunction

  function automatic logic [31:0] model(int k, logic [31:0] a, logic [31:0] b);
    case (k)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return {a[31:16] + b[31:16], a[15:0] + b[15:0]};
      default: return {a[31:16] - b[31:16], a[15:0] - b[15:0]};
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(int a, logic [15:0] w);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = a[5:0]; ld_data = w;
    @(posedge clk); #1 ld_we = 1'b0;
  endtask

  task automatic send(int ch, logic [31:0] d, int dly);
    repeat (dly) @(negedge clk);
    in_data[ch] = d; in_valid[ch] = 1'b1;
    #1;
    while (!in_accept[ch]) begin @(negedge clk); #1; end
    @(posedge clk); #1 in_valid[ch] = 1'b0;
  endtask

  task automatic recv(int ch, int dly, output logic [31:0] d, output int when);
    repeat (dly) @(negedge clk);
    out_accept[ch] = 1'b1;
    #1;
    while (!out_valid[ch]) begin @(negedge clk); #1; end
    d = out_data[ch]; when = cyc;
    @(posedge clk); #1 out_accept[ch] = 1'b0;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 2'b11; out_accept = 2'b00;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nerr++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] got;
    int t [5];
    int tt;
    ld_we = 1'b0; ld_addr = '0; ld_data = '0;
    in_data = '0; in_valid = '0; out_accept = '0;
    rst_n = 1'b0;

    // R10: quiet while in reset even with inputs offered
    enter_reset();
    check("R10 out_valid in reset", 32'(out_valid), 32'h0);
    check("R10 in_accept in reset", 32'(in_accept), 32'h0);

    // program A: r1<-in0, r2<-in1, seven ops to out0, jump to 0 via r0
    load(0, enc(6, 1, 0, 0, 3'b100));
    load(1, enc(6, 2, 1, 0, 3'b100));
    load(2, enc(1, 0, 1, 2, 3'b010));
    load(3, enc(2, 0, 1, 2, 3'b010));
    load(4, enc(3, 0, 1, 2, 3'b010));
    load(5, enc(4, 0, 1, 2, 3'b010));
    load(6, enc(5, 0, 1, 2, 3'b010));
    load(7, enc(7, 0, 1, 2, 3'b010));
    load(8, enc(8, 0, 1, 2, 3'b010));
    load(9, enc(10, 0, 0, 0, 0));
    @(negedge clk); in_valid = 2'b00; rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      logic [31:0] va, vb;
      va = VEC[i][63:32]; vb = VEC[i][31:0];
      fork
        begin
          send(0, va, i % 2);
          send(1, vb, i % 2);
        end
        begin
          for (int k = 0; k < 7; k++) begin
            int w;
            if (i == 0 && k == 0) begin
              repeat (10) @(negedge clk); #1;
              // R7: result slot full, next push blocked, nothing drained
              check("R6 held out0_valid", 32'(out_valid[0]), 32'h1);
              check("R6 held out0_data", out_data[0], model(0, va, vb));
              check("R7 no input taken while stalled", 32'(in_accept), 32'h0);
            end
            recv(0, (i + k) % 3, got, w);
            if (k == 0)      check("R4 channel operand add", got, model(k, va, vb));
            else if (k < 5)  check("R1 alu op", got, model(k, va, vb));
            else             check("R2 dual-half op", got, model(k, va, vb));
          end
        end
      join
    end

    // program B: loop, memory, branches
    enter_reset();
    load(0, enc(9, 3, 0, 0, 4));           // r3 = 4
    load(1, enc(11, 0, 3, 0, 2));          // loop count r3, end at 2
    load(2, enc(6, 1, 0, 0, 3'b110));      // out1 <- in0
    load(3, enc(9, 4, 1, 2, 5));           // r4 = 0x55
    load(4, enc(10, 0, 4, 0, 0));          // r4 nonzero: fall through
    load(5, enc(13, 0, 4, 5, 0));          // mem[40] = r4
    load(6, enc(12, 5, 0, 5, 0));          // r5 = mem[40]
    load(7, enc(6, 1, 5, 0, 3'b010));      // out1 <- r5
    load(8, enc(9, 6, 7, 7, 7));           // r6 = 0x1FF
    load(9, enc(1, 1, 6, 4, 3'b010));      // out1 <- r6 + r4
    load(10, enc(10, 0, 0, 1, 2));         // spin at 10
    @(negedge clk); in_valid = 2'b00; rst_n = 1'b1;

    fork
      begin
        for (int j = 0; j < 5; j++) send(0, 32'hC0DE0000 + 32'(j), 0);
      end
      begin
        for (int j = 0; j < 5; j++) begin
          recv(1, 0, got, tt);
          t[j] = tt;
          check("R5 forwarded word in order", got, 32'hC0DE0000 + 32'(j));
        end
      end
    join
    for (int j = 1; j < 5; j++)
      check("R3 loop body back to back", 32'(t[j] - t[j-1]), 32'd1);

    recv(1, 0, got, tt);
    check("R9 store then load", got, 32'h00000055);
    recv(1, 0, got, tt);
    check("R8 fall-through then add", got, 32'h00000254);

    // R8: taken self-jump spins, no further traffic
    @(negedge clk);
    in_data[0] = 32'h1234; in_valid[0] = 1'b1;
    repeat (10) @(negedge clk);
    #1;
    check("R8 spin no out1", 32'(out_valid[1]), 32'h0);
    check("R8 spin no input taken", 32'(in_accept[0]), 32'h0);
    in_valid[0] = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule